// File: doc/BRIEF.md
# Audio Serial Clock Unit Generator

This block produces the timing for one audio serial port clock unit acting as the clock source. A single reference clock drives every register. From it the block derives three strobes and levels: a master clock, a serial bit clock and a frame sync. It also reports the position of the current bit within its slot and of the slot within its frame, so that transmit and receive serializers can align their shift registers. The unit runs by itself, whether or not a serializer is active.

All four configuration fields are programmed as the wanted value minus one. The master clock divide code is captured when the unit starts from idle. The bit clock divide code, the slot count code and the slot size code are captured at start and again at every frame boundary, so a change made in the middle of a frame does not tear that frame. Clearing the enable does not cut a frame short. The unit finishes the frame that is in progress, then returns to idle and drops its running flag.

Output levels are registered at the reference rate. A divide factor of one holds the corresponding level high and asserts its strobe every cycle. The consumer then forwards the reference clock itself.

Top module: `audclk_unit`

## Requirements
- R1: While running, `mck_tick` is high once every M+1 reference cycles, where M is the captured master divide code, starting in the first running cycle. `mck_clk` is low for the first floor((M+1)/2) cycles of each such period and high for the rest.
- R2: While running, `sck_tick` is high in the first reference cycle of each bit period, and a bit period lasts S+1 cycles, where S is the captured bit clock divide code. `sck_clk` is low for the first floor((S+1)/2) cycles of each bit period and high for the rest, so with S=0 it stays high.
- R3: A frame holds N+1 slots, where N is the slot count code. `slot_idx` counts 0 to N and advances after the last bit of each slot.
- R4: A slot holds 8×(Z+1) bits, where Z is the 2-bit slot size code (0→8, 1→16, 2→24, 3→32). `bit_idx` counts from 0 and advances once per bit period.
- R5: A frame lasts (S+1)×(N+1)×8×(Z+1) reference cycles. `fsync` is high exactly while `slot_idx` is 0, and it changes only in a cycle where `sck_tick` is high.
- R6: When `enable` is seen high while idle, the next cycle is the first cycle of bit 0 of slot 0, with `running`, `sck_tick` and `mck_tick` all high.
- R7: When `enable` is low during the last reference cycle of a frame, `running` falls in the next cycle. If `enable` is high at that point, a new frame starts at once, even if `enable` was low earlier in the frame.
- R8: While idle and during reset, all clock, strobe and sync outputs are low and both indices are 0.
- R9: Changes to the bit clock divide, slot count and slot size codes made during a frame take effect from the next frame. The master divide code is taken only when starting from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock driving all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request for the clock unit |
| mck_div_code | input | MCK_DIV_W | Master clock divide factor minus one |
| sck_div_code | input | SCK_DIV_W | Bit clock divide factor minus one |
| slot_cnt_code | input | SLOT_CODE_W | Slots per frame minus one |
| slot_size_code | input | 2 | Slot width: 8×(code+1) bits |
| running | output | 1 | Unit is producing clocks |
| mck_tick | output | 1 | Start of a master clock period |
| mck_clk | output | 1 | Master clock level |
| sck_tick | output | 1 | Start of a bit period (bit clock falling edge) |
| sck_clk | output | 1 | Bit clock level |
| fsync | output | 1 | Frame sync, high during slot 0 |
| slot_idx | output | SLOT_CODE_W | Slot number within the frame |
| bit_idx | output | 5 | Bit number within the slot |

## Verification
The hardest case to reach is the end-of-frame decision. The stop has to land on the exact last reference cycle of a frame, and the bit clock and slot codes may have been rewritten in that same frame. Directed runs lower `enable` partway through a frame and raise it again before the boundary. They also change the configuration a few cycles into a frame. Random episodes then toggle `enable` and reload all four codes at arbitrary cycles with small divide factors, so that many frame boundaries meet a pending stop or a pending change. A cycle-level model in the bench compares every output in every cycle.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
  localparam int SIZE_W = 2;
  localparam int BIT_W  = SIZE_W + 3;

  // index of the final bit in a slot of 8*(code+1) bits
  function automatic logic [BIT_W-1:0] last_bit_of(input logic [SIZE_W-1:0] code);
    return {code, 3'b111};
  endfunction
endpackage

// File: rtl/audclk_div.sv
module audclk_div #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] div_code,
  output logic         tick,
  output logic         wrap,
  output logic         lvl
);
  logic [W-1:0] cnt;
  logic [W:0]   half;

  assign half = ({1'b0, div_code} + 1'b1) >> 1;
  assign tick = run && (cnt == '0);
  assign wrap = run && (cnt >= div_code);
  assign lvl  = run && ({1'b0, cnt} >= half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (wrap)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R2 (and R1 for the master instance): the phase never passes the factor
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= div_code));
endmodule

// File: rtl/audclk_frame.sv
module audclk_frame import audclk_pkg::*; #(
  parameter int SLOT_CODE_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic                   bit_wrap,
  input  logic [SIZE_W-1:0]      size_code,
  input  logic [SLOT_CODE_W-1:0] slot_code,
  output logic [BIT_W-1:0]       bit_idx,
  output logic [SLOT_CODE_W-1:0] slot_idx,
  output logic                   frame_end
);
  logic bit_last, slot_last;

  assign bit_last  = (bit_idx == last_bit_of(size_code));
  assign slot_last = (slot_idx == slot_code);
  assign frame_end = bit_wrap && bit_last && slot_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx  <= '0;
      slot_idx <= '0;
    end else if (!run) begin
      bit_idx  <= '0;
      slot_idx <= '0;
    end else if (bit_wrap) begin
      if (bit_last) begin
        bit_idx  <= '0;
        slot_idx <= slot_last ? '0 : slot_idx + 1'b1;
      end else begin
        bit_idx  <= bit_idx + 1'b1;
      end
    end
  end

  assert_bit_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (bit_idx <= last_bit_of(size_code)));
  assert_slot_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (slot_idx <= slot_code));
endmodule

// File: rtl/audclk_unit.sv
module audclk_unit import audclk_pkg::*; #(
  parameter int MCK_DIV_W   = 6,
  parameter int SCK_DIV_W   = 8,
  parameter int SLOT_CODE_W = 3
) (
  input  logic                   ref_clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic [MCK_DIV_W-1:0]   mck_div_code,
  input  logic [SCK_DIV_W-1:0]   sck_div_code,
  input  logic [SLOT_CODE_W-1:0] slot_cnt_code,
  input  logic [SIZE_W-1:0]      slot_size_code,
  output logic                   running,
  output logic                   mck_tick,
  output logic                   mck_clk,
  output logic                   sck_tick,
  output logic                   sck_clk,
  output logic                   fsync,
  output logic [SLOT_CODE_W-1:0] slot_idx,
  output logic [BIT_W-1:0]       bit_idx
);
  logic [MCK_DIV_W-1:0]   cfg_mck;
  logic [SCK_DIV_W-1:0]   cfg_sck;
  logic [SLOT_CODE_W-1:0] cfg_slots;
  logic [SIZE_W-1:0]      cfg_size;
  logic sck_wrap, mck_wrap, frame_end;

  // run control: start from idle, stop or reload only at a frame boundary
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      cfg_mck   <= '0;
      cfg_sck   <= '0;
      cfg_slots <= '0;
      cfg_size  <= '0;
    end else if (!running) begin
      if (enable) begin
        running   <= 1'b1;
        cfg_mck   <= mck_div_code;
        cfg_sck   <= sck_div_code;
        cfg_slots <= slot_cnt_code;
        cfg_size  <= slot_size_code;
      end
    end else if (frame_end) begin
      if (!enable) begin
        running <= 1'b0;
      end else begin
        cfg_sck   <= sck_div_code;
        cfg_slots <= slot_cnt_code;
        cfg_size  <= slot_size_code;
      end
    end
  end

  audclk_div #(.W(MCK_DIV_W)) u_mck (
    .clk(ref_clk), .rst_n(rst_n), .run(running), .div_code(cfg_mck),
    .tick(mck_tick), .wrap(mck_wrap), .lvl(mck_clk)
  );

  audclk_div #(.W(SCK_DIV_W)) u_sck (
    .clk(ref_clk), .rst_n(rst_n), .run(running), .div_code(cfg_sck),
    .tick(sck_tick), .wrap(sck_wrap), .lvl(sck_clk)
  );

  audclk_frame #(.SLOT_CODE_W(SLOT_CODE_W)) u_frame (
    .clk(ref_clk), .rst_n(rst_n), .run(running), .bit_wrap(sck_wrap),
    .size_code(cfg_size), .slot_code(cfg_slots),
    .bit_idx(bit_idx), .slot_idx(slot_idx), .frame_end(frame_end)
  );

  assign fsync = running && (slot_idx == '0);

  assert_start_on_enable_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(running) |-> $past(enable));
  assert_stop_at_boundary_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(running) |-> ($past(frame_end) && !$past(enable)));
  assert_fs_rise_on_bit_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(fsync) |-> sck_tick);
  assert_fs_fall_on_bit_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ($fell(fsync) && running) |-> sck_tick);
  assert_mck_restart_R1: assert property (@(posedge ref_clk) disable iff (!rst_n)
    mck_wrap |=> (mck_tick || !running));
  assert_idle_quiet_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !running |-> (!mck_clk && !sck_clk && !fsync && slot_idx == '0 && bit_idx == '0));
endmodule

// File: tb/sim_audclk_unit.sv
module sim_audclk_unit;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 6, SW = 8, NW = 3;

  logic ref_clk = 1'b0;
  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

  logic rst_n, enable;
  logic [MW-1:0] mck_div_code;
  logic [SW-1:0] sck_div_code;
  logic [NW-1:0] slot_cnt_code;
  logic [1:0]    slot_size_code;
  logic running, mck_tick, mck_clk, sck_tick, sck_clk, fsync;
  logic [NW-1:0] slot_idx;
  logic [4:0]    bit_idx;

  audclk_unit #(.MCK_DIV_W(MW), .SCK_DIV_W(SW), .SLOT_CODE_W(NW)) u0 (
    .ref_clk(ref_clk), .rst_n(rst_n), .enable(enable),
    .mck_div_code(mck_div_code), .sck_div_code(sck_div_code),
    .slot_cnt_code(slot_cnt_code), .slot_size_code(slot_size_code),
    .running(running), .mck_tick(mck_tick), .mck_clk(mck_clk),
    .sck_tick(sck_tick), .sck_clk(sck_clk), .fsync(fsync),
    .slot_idx(slot_idx), .bit_idx(bit_idx)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit m_run = 0;
  int t = 0, tm = 0, mM = 0, mS = 0, mN = 0, mZ = 0;

  function automatic int frame_len();
    return (mS + 1) * (mN + 1) * 8 * (mZ + 1);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic compare();
    int f, bp, ph, bits, mf, mp;
    int e_bit = 0, e_slot = 0, e_st = 0, e_sc = 0, e_fs = 0, e_mt = 0, e_mc = 0;
    if (m_run) begin
      f = mS + 1; bits = 8 * (mZ + 1);
      bp = t / f; ph = t % f;
      e_bit = bp % bits; e_slot = bp / bits;
      e_st = (ph == 0); e_sc = (ph >= f / 2); e_fs = (e_slot == 0);
      mf = mM + 1; mp = tm % mf;
      e_mt = (mp == 0); e_mc = (mp >= mf / 2);
    end
    chk("R7", "running", int'(running), int'(m_run));
    chk("R1", "mck_tick", int'(mck_tick), e_mt);
    chk("R1", "mck_clk", int'(mck_clk), e_mc);
    chk("R2", "sck_tick", int'(sck_tick), e_st);
    chk("R2", "sck_clk", int'(sck_clk), e_sc);
    chk("R5", "fsync", int'(fsync), e_fs);
    chk("R3", "slot_idx", int'(slot_idx), e_slot);
    chk("R4", "bit_idx", int'(bit_idx), e_bit);
  endtask

  // one reference cycle: model follows the edge, outputs are checked mid-cycle
  task automatic tick();
    @(posedge ref_clk);
    cyc++;
    if (rst_n) begin
      if (!m_run) begin
        if (enable) begin
          m_run = 1; t = 0; tm = 0;
          mM = mck_div_code; mS = sck_div_code; mN = slot_cnt_code; mZ = slot_size_code;
        end
      end else if (t == frame_len() - 1) begin
        if (!enable) begin
          m_run = 0; t = 0; tm = 0;
        end else begin
          mS = sck_div_code; mN = slot_cnt_code; mZ = slot_size_code;
          t = 0; tm++;
        end
      end else begin
        t++; tm++;
      end
    end
    @(negedge ref_clk);
    compare();
  endtask

  task automatic set_cfg(input int m, input int s, input int n, input int z);
    mck_div_code = MW'(m); sck_div_code = SW'(s);
    slot_cnt_code = NW'(n); slot_size_code = 2'(z);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_run();
    enable = 1'b0;
    for (int i = 0; i < 9000 && m_run; i++) tick();
    run(3);
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b0;
    set_cfg(3, 2, 4, 1);
    void'($urandom(32'h1A2B3C4D));
    @(negedge ref_clk);
    compare();                       // R8 during reset
    run(3);
    rst_n = 1'b1;
    run(5);                          // R8: idle with non-zero codes

    // reference example: factors 1 and 2, 6 slots of 32 bits; stop mid-frame (R7)
    set_cfg(0, 1, 5, 3);
    enable = 1'b1;
    tick();                          // R6: first running cycle is bit 0 of slot 0
    run(520);
    finish_run();

    // bit clock factor 1, single 8-bit slot; cancelled stop (R7)
    set_cfg(1, 0, 0, 0);
    enable = 1'b1; run(21);
    enable = 1'b0; run(3);
    enable = 1'b1; run(20);
    finish_run();

    // mid-frame change applies at the next frame (R9)
    set_cfg(2, 2, 1, 1);
    enable = 1'b1; run(10);
    set_cfg(4, 1, 2, 0);
    run(250);
    finish_run();

    // one-cycle enable pulse still yields a whole frame (R6, R7)
    set_cfg(0, 3, 1, 0);
    enable = 1'b1; tick();
    enable = 1'b0;
    finish_run();

    // random episodes
    for (int ep = 0; ep < 30; ep++) begin
      int len = 200 + int'($urandom_range(2800));
      set_cfg(int'($urandom_range(7)), int'($urandom_range(3)),
              int'($urandom_range(7)), int'($urandom_range(3)));
      enable = 1'b1;
      for (int i = 0; i < len; i++) begin
        if ($urandom_range(399) == 0) enable = ~enable;
        if ($urandom_range(299) == 0)
          set_cfg(int'($urandom_range(7)), int'($urandom_range(3)),
                  int'($urandom_range(7)), int'($urandom_range(3)));
        tick();
      end
      finish_run();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_tests++; n_fail++;
    $display("FAIL R7 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule